// File: doc/BRIEF.md
# Dual-Channel Double-Buffered DAC Code Register Front End

This block is the clocked digital front end for a converter with two 16-bit channels. A host presents a word on a parallel data bus together with a two-bit channel select and strobes an active-low write line; the word lands in a staging (input) register of one channel, of both channels, or of neither. A separate active-high load line copies both staging registers into the code registers that drive the converter, so that the two channel outputs change in the same clock cycle.

All strobes are asynchronous to the block clock. They pass through a two-stage synchronizer, and the bus and select lines pass through the same two stages so that the word captured is the one present when the write strobe was first seen low. A clear pin, a clear-value select and an internal power-up hold force all four registers to zero or to midscale. Tying the write and load lines together gives a one-wire mode: the falling edge stages the word and the rising edge publishes it.

Top module: `dual_dac_regs`

## Requirements
- R1: Whenever the block is being cleared, every staging and code register takes 0x0000 if `clr_sel` is 0 and 0x8000 (only bit 15 set, bit 15 being the most significant) if `clr_sel` is 1; this also holds during the synchronous `rst_n` reset.
- R2: Holding `clr_n` low clears all registers whatever `wr_n`, `load` and the bus do; the clear value appears at the outputs after the third rising clock edge that samples `clr_n` low, and writes seen while clearing are lost.
- R3: For `POR_CYCLES` clocks after `rst_n` is released the block stays cleared as in R1, and strobes in that window have no effect.
- R4: The select `ch_sel[1:0]` routes a write as follows: 2'b00 to channel A, 2'b11 to channel B, 2'b10 to both channels, 2'b01 to no channel.
- R5: Each falling edge of `wr_n` writes exactly once; the word and select used are those present on the clock edge that first sampled `wr_n` low, so later bus changes while `wr_n` stays low are ignored.
- R6: A write made while `load` is low changes no output.
- R7: While `load` is high, both code registers take their staging values on the same clock edge; a `load` level first sampled on edge k shows on the outputs after edge k+2.
- R8: With `wr_n` and `load` driven as one wire, its falling edge stages the word without changing the outputs and its rising edge publishes it.
- R9: While `wr_n` stays high and `load` stays low, bus and select activity changes no register.
- R10: With `load` held high, each write reaches the outputs one clock after it reaches the staging register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low system reset; release starts the power-up hold |
| dbus | input | DATA_W | Parallel data word, bit DATA_W-1 most significant |
| ch_sel | input | 2 | Channel select for writes (see R4) |
| wr_n | input | 1 | Active-low write strobe, asynchronous |
| load | input | 1 | Active-high publish strobe, asynchronous |
| clr_n | input | 1 | Active-low clear pin, asynchronous |
| clr_sel | input | 1 | Clear value select: 0 zero, 1 midscale (assumed static) |
| code_a | output | DATA_W | Channel A code register |
| code_b | output | DATA_W | Channel B code register |

## Verification
The interesting collisions are a write edge arriving on the same clock as a publish (the transparent and one-wire modes) and a clear arriving while write and publish strobes are both active. The bench drives `wr_n` low with `load` already high, drives both lines as one wire, and drops `clr_n` in the middle of a write with `load` raised during the clear. A behavioural model built from sample queues predicts both codes on every clock, and any difference in either channel is reported against the requirement being exercised.

// File: rtl/dacif_pkg.sv
// Package: shared types and the channel-select decode for the dual DAC
// register front end. Assumes two channels, A at index 0 and B at index 1.
package dacif_pkg;

    localparam int NUM_CH = 2;

    // Channel-select codes; the encoding is fixed by the host protocol.
    typedef enum logic [1:0] {
        SEL_CH_A  = 2'b00,
        SEL_NONE  = 2'b01,
        SEL_BOTH  = 2'b10,
        SEL_CH_B  = 2'b11
    } ch_sel_e;

    // Returns a per-channel write mask: bit 0 = channel A, bit 1 = channel B.
    function automatic logic [NUM_CH-1:0] sel_mask(input logic [1:0] code);
        logic [NUM_CH-1:0] m;
        case (ch_sel_e'(code))
            SEL_CH_A: m = 2'b01;
            SEL_CH_B: m = 2'b10;
            SEL_BOTH: m = 2'b11;
            default:  m = 2'b00;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/dacif_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is either a level or held long enough for STAGES clocks;
// on rst_n every stage is loaded with IDLE so no false edge follows reset.
module dacif_sync #(
    parameter int              W      = 1,
    parameter int              STAGES = 2,
    parameter logic [W-1:0]    IDLE   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    // Shift the asynchronous vector through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= IDLE;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/dacif_por.sv
// Module: power-up hold. Keeps por_active high for HOLD clocks after rst_n
// is released. Assumes HOLD >= 1.
module dacif_por #(
    parameter int HOLD = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic por_active
);

    localparam int CNT_W = $clog2(HOLD + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD);

    logic [CNT_W-1:0] cnt;

    // Count clocks since reset release, saturating at HOLD.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (cnt != LAST)  cnt <= cnt + 1'b1;
    end

    assign por_active = (cnt != LAST);

endmodule

// File: rtl/dacif_chan.sv
// Module: one channel's staging register and code register.
// Assumes clear, wr_en and load come from the synchronized domain; clear
// has priority, then a write to staging and a publish happen independently
// (a publish in the same cycle as a write takes the old staging value).
module dacif_chan #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [DATA_W-1:0] clr_val,
    input  logic              wr_en,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] stage_code,
    output logic [DATA_W-1:0] out_code
);

    // Update staging and code registers; clear wins over any strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            stage_code <= clr_val;
            out_code   <= clr_val;
        end else begin
            if (wr_en) stage_code <= din;
            if (load)  out_code   <= stage_code;
        end
    end

    assert_clear_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (stage_code == $past(clr_val) && out_code == $past(clr_val)));

    assert_hold_without_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !load) |=> $stable(out_code));

endmodule

// File: rtl/dual_dac_regs.sv
// Module: dual-channel double-buffered DAC code register front end.
// Synchronizes the write, publish and clear strobes together with the bus
// and select, detects write falling edges, decodes the channel select and
// holds all registers at the clear value during clear and power-up.
// Assumes clr_sel is static while the block runs.
module dual_dac_regs #(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2,
    parameter int POR_CYCLES  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] dbus,
    input  logic [1:0]        ch_sel,
    input  logic              wr_n,
    input  logic              load,
    input  logic              clr_n,
    input  logic              clr_sel,
    output logic [DATA_W-1:0] code_a,
    output logic [DATA_W-1:0] code_b
);
    import dacif_pkg::*;

    localparam int               PAY_W  = DATA_W + 2;
    localparam logic [DATA_W-1:0] MID   = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [2:0]       CTL_IDLE = 3'b101; // {clr_n, load, wr_n}

    logic [2:0]        ctl_s;
    logic [PAY_W-1:0]  pay_s;
    logic              wr_s, load_s, clr_s;
    logic [1:0]        sel_s;
    logic [DATA_W-1:0] data_s;
    logic              wr_prev, wr_fall, por_active, clear;
    logic [DATA_W-1:0] clr_val;
    logic [NUM_CH-1:0] wr_mask;
    logic [DATA_W-1:0] stage_codes [NUM_CH];
    logic [DATA_W-1:0] out_codes   [NUM_CH];

    dacif_sync #(.W(3), .STAGES(SYNC_STAGES), .IDLE(CTL_IDLE)) i_ctl_sync (
        .clk(clk), .rst_n(rst_n), .d({clr_n, load, wr_n}), .q(ctl_s));

    dacif_sync #(.W(PAY_W), .STAGES(SYNC_STAGES), .IDLE('0)) i_pay_sync (
        .clk(clk), .rst_n(rst_n), .d({ch_sel, dbus}), .q(pay_s));

    dacif_por #(.HOLD(POR_CYCLES)) i_por (
        .clk(clk), .rst_n(rst_n), .por_active(por_active));

    assign {clr_s, load_s, wr_s} = ctl_s;
    assign {sel_s, data_s}       = pay_s;

    // Remember the previous synchronized write level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_prev <= 1'b1;
        else        wr_prev <= wr_s;
    end

    // Combine clear sources, pick the clear value and decode the write.
    always_comb begin
        wr_fall = wr_prev & ~wr_s;
        clear   = por_active | ~clr_s;
        clr_val = clr_sel ? MID : '0;
        wr_mask = sel_mask(sel_s) & {NUM_CH{wr_fall}};
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        dacif_chan #(.DATA_W(DATA_W)) i_chan (
            .clk(clk), .rst_n(rst_n), .clear(clear), .clr_val(clr_val),
            .wr_en(wr_mask[c]), .load(load_s), .din(data_s),
            .stage_code(stage_codes[c]), .out_code(out_codes[c]));
    end

    assign code_a = out_codes[0];
    assign code_b = out_codes[1];

    assert_single_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fall |=> !wr_fall);

    assert_no_channel_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fall && sel_s == 2'b01 && !clear) |=>
            ($stable(stage_codes[0]) && $stable(stage_codes[1])));

    assert_joint_publish_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_s && !clear) |=>
            (out_codes[0] == $past(stage_codes[0]) && out_codes[1] == $past(stage_codes[1])));

    assert_powerup_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        por_active |=> (code_a == $past(clr_val) && code_b == $past(clr_val)));

endmodule

// File: tb/test_dual_dac_regs.sv
// Bench: behavioural queue-based model of the front end, compared with both
// code outputs on every falling clock edge.
module test_dual_dac_regs;

    localparam int POR = 16;

    typedef struct packed {
        logic        wr;
        logic        ld;
        logic        clr;
        logic [1:0]  a;
        logic [15:0] d;
    } smp_t;

    localparam smp_t IDLE_SMP = '{wr: 1'b1, ld: 1'b0, clr: 1'b1, a: 2'b00, d: 16'h0000};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] dbus = '0;
    logic [1:0]  ch_sel = '0;
    logic        wr_n = 1'b1;
    logic        load = 1'b0;
    logic        clr_n = 1'b1;
    logic        clr_sel = 1'b0;
    logic [15:0] code_a, code_b;

    int    checks = 0;
    int    fails  = 0;
    bit    armed  = 1'b0;
    bit    done   = 1'b0;
    string cur_req = "R1";

    smp_t        pipe[$];
    int          por_cnt = 0;
    logic        m_prev = 1'b1;
    logic [15:0] m_stage [2];
    logic [15:0] m_out   [2];

    dual_dac_regs #(.DATA_W(16), .SYNC_STAGES(2), .POR_CYCLES(POR)) i_dual_dac_regs (
        .clk(clk), .rst_n(rst_n), .dbus(dbus), .ch_sel(ch_sel), .wr_n(wr_n),
        .load(load), .clr_n(clr_n), .clr_sel(clr_sel), .code_a(code_a), .code_b(code_b));

    always #5ns clk = ~clk;

    // Reference model: two-sample queue delay, edge on write, level on load.
    always @(posedge clk) begin
        smp_t        cur;
        logic [15:0] rv;
        logic [15:0] old0, old1;
        rv = clr_sel ? 16'h8000 : 16'h0000;
        if (!rst_n) begin
            pipe = {IDLE_SMP, IDLE_SMP};
            m_prev = 1'b1;
            por_cnt = 0;
            m_stage[0] = rv; m_stage[1] = rv; m_out[0] = rv; m_out[1] = rv;
        end else begin
            cur = pipe.pop_front();
            pipe.push_back('{wr: wr_n, ld: load, clr: clr_n, a: ch_sel, d: dbus});
            if (por_cnt < POR || !cur.clr) begin
                m_stage[0] = rv; m_stage[1] = rv; m_out[0] = rv; m_out[1] = rv;
            end else begin
                old0 = m_stage[0];
                old1 = m_stage[1];
                if (m_prev && !cur.wr) begin
                    if (cur.a == 2'b00 || cur.a == 2'b10) m_stage[0] = cur.d;
                    if (cur.a == 2'b11 || cur.a == 2'b10) m_stage[1] = cur.d;
                end
                if (cur.ld) begin
                    m_out[0] = old0;
                    m_out[1] = old1;
                end
            end
            m_prev = cur.wr;
            if (por_cnt < POR) por_cnt++;
        end
    end

    // Compare both channels with the model away from the active edge.
    always @(negedge clk) begin
        if (armed && !done) begin
            checks++;
            if (code_a !== m_out[0]) begin
                fails++;
                $display("FAIL %s channel A: actual %h expected %h at %0t", cur_req, code_a, m_out[0], $time);
            end
            checks++;
            if (code_b !== m_out[1]) begin
                fails++;
                $display("FAIL %s channel B: actual %h expected %h at %0t", cur_req, code_b, m_out[1], $time);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        ch_sel = a; dbus = d; wr_n = 1'b0;
        cyc(3);
        wr_n = 1'b1;
        cyc(3);
    endtask

    task automatic publish();
        @(negedge clk);
        load = 1'b1;
        cyc(3);
        load = 1'b0;
        cyc(3);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #2_000_000ns;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state with zero clear value
        cur_req = "R1";
        cyc(1);
        armed = 1'b1;
        cyc(4);
        rst_n = 1'b1;
        // R3: strobes inside the power-up hold are lost
        cur_req = "R3";
        host_write(2'b10, 16'h1234);
        publish();
        cyc(10);
        // R4: every select code
        cur_req = "R4";
        host_write(2'b00, 16'hA111);
        host_write(2'b11, 16'hB222);
        host_write(2'b01, 16'hDEAD);
        publish();
        host_write(2'b10, 16'hC333);
        publish();
        // R6: write without publish leaves outputs
        cur_req = "R6";
        host_write(2'b00, 16'h1111);
        cyc(4);
        // R5: one capture per falling edge, first-sampled word
        cur_req = "R5";
        @(negedge clk);
        ch_sel = 2'b11; dbus = 16'h5555; wr_n = 1'b0;
        cyc(3);
        dbus = 16'h6666; ch_sel = 2'b00;
        cyc(4);
        wr_n = 1'b1;
        cyc(3);
        publish();
        // R9: bus activity with write high and load low
        cur_req = "R9";
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            dbus = 16'h0F00 + 16'(i);
            ch_sel = 2'(i);
        end
        cyc(4);
        publish();
        // R8: write and load driven as one wire
        cur_req = "R8";
        @(negedge clk);
        ch_sel = 2'b10; dbus = 16'h7777; wr_n = 1'b0; load = 1'b0;
        cyc(4);
        wr_n = 1'b1; load = 1'b1;
        cyc(4);
        load = 1'b0;
        cyc(3);
        // R10: transparent mode with load held high
        cur_req = "R10";
        @(negedge clk);
        load = 1'b1;
        host_write(2'b00, 16'h9999);
        host_write(2'b11, 16'hAAAA);
        load = 1'b0;
        cyc(3);
        // R2: clear during active write and publish
        cur_req = "R2";
        @(negedge clk);
        ch_sel = 2'b10; dbus = 16'h4242; wr_n = 1'b0; clr_n = 1'b0;
        cyc(2);
        load = 1'b1;
        cyc(3);
        clr_n = 1'b1; wr_n = 1'b1; load = 1'b0;
        cyc(4);
        publish();
        // R1: midscale clear value, staging registers checked by a publish
        cur_req = "R1";
        clr_sel = 1'b1;
        @(negedge clk);
        clr_n = 1'b0;
        cyc(4);
        clr_n = 1'b1;
        cyc(3);
        publish();
        // R7: joint publish of two different words
        cur_req = "R7";
        host_write(2'b00, 16'h0F0F);
        host_write(2'b11, 16'hF0F0);
        publish();
        cyc(2);
        finish_run();
    end

endmodule